// File: doc/BRIEF.md
# Type II Digital Angle Tracking Loop

This block is the digital part of a tracking angle converter. On each strobed sample it takes a signed error word proportional to sin(theta - phi), where theta is the measured shaft angle and phi is the block's own angle. It uses that error to keep its angle word following the shaft. The error goes into a saturating velocity integrator. A proportional lead term is added to the integrated velocity to form a rate command. The command passes through a one-pole lag. The lagged rate then feeds a phase accumulator, and each carry or borrow out of that accumulator moves a wrapping up/down angle counter by one LSB. The result is a double-integrator servo with a stabilising zero.

The angle is natural binary, so its top bit is the half-turn. The velocity word is signed and is positive while the angle increases. All gains are powers of two, so the datapath needs only adders and shifts. The sine/cosine front end and the error computation are outside this block. The error arrives already formed, with a valid strobe.

Top module: `angle_track_loop`

## Requirements
- R1: A synchronous active-high reset clears the angle, the velocity, the lagged rate and the phase accumulator to zero, and with no error strobes afterwards the angle stays at zero.
- R2: On every cycle with `err_valid` high, the velocity becomes velocity + error * 2^KI_SHIFT. With `err_valid` low, the velocity keeps its value whatever `err_sample` holds.
- R3: The velocity saturates at +(2^(VEL_W-1) - 1) and at -2^(VEL_W-1) instead of wrapping. A positive error never lowers it.
- R4: Every clock, the lagged rate is added to a phase accumulator of VEL_W-1 fraction bits. A carry steps the angle up by exactly one LSB, a borrow steps it down by one, and the angle never moves by more than one LSB per clock.
- R5: The angle counter wraps modulo 2^ANGLE_W in both directions (the maximum code steps up to zero, zero steps down to the maximum code).
- R6: On a strobe, the rate command is the updated velocity plus error * 2^KP_SHIFT, saturated to the velocity range. This is the lead path.
- R7: On a strobe, the lagged rate moves by (command - lagged rate) arithmetically shifted right by LAG_SHIFT, rounding toward minus infinity. It never passes the command.
- R8: Closed around an error equal to the wrapped angle difference, the loop brings the angle to within 3 LSB of a fixed target, from below and from above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Strobe marking a new error sample |
| err_sample | input | ERR_W | Signed error sample, sin(theta - phi) scaled |
| angle_o | output | ANGLE_W | Tracked angle, natural binary, MSB = 180 degrees |
| vel_o | output | VEL_W | Signed velocity, positive for increasing angle |

## Verification
A single strobe is swept over every error code from a cleared state. This separates the integrator gain, its sign handling and the ignoring of unstrobed samples. Long runs of maximum positive and then maximum negative error drive the velocity into both rails and spin the angle through both wrap points. Single strobes of +1 and -1 followed by free running separate the lead contribution and the floor rounding of the lag from a truncating version, because the two roundings end on different angles. Two closed-loop runs toward targets above and below the start show that the signs around the whole loop agree.

// File: rtl/atl_pkg.sv
package atl_pkg;

  // Direction of a single angle step produced by the phase accumulator
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/atl_vel_integrator.sv
// Saturating velocity integrator plus proportional lead path.
// Requires ERR_W + KI_SHIFT <= VEL_W and ERR_W + KP_SHIFT <= VEL_W.
module atl_vel_integrator #(
  parameter int ERR_W    = 12,
  parameter int VEL_W    = 20,
  parameter int KI_SHIFT = 0,
  parameter int KP_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err_sample,
  output logic signed [VEL_W-1:0] vel_q,
  output logic signed [VEL_W-1:0] cmd_o
);

  localparam int EXT_W = VEL_W + 2;
  localparam logic signed [EXT_W-1:0] VMAX = {3'b000, {(VEL_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] VMIN = {3'b111, {(VEL_W-1){1'b0}}};

  function automatic logic signed [VEL_W-1:0] clip(input logic signed [EXT_W-1:0] x);
    if (x > VMAX)      return VMAX[VEL_W-1:0];
    else if (x < VMIN) return VMIN[VEL_W-1:0];
    else               return x[VEL_W-1:0];
  endfunction

  logic signed [EXT_W-1:0] err_ext;
  logic signed [EXT_W-1:0] ki_term;
  logic signed [EXT_W-1:0] kp_term;
  logic signed [EXT_W-1:0] vel_sum;
  logic signed [EXT_W-1:0] cmd_sum;
  logic signed [VEL_W-1:0] vel_nxt;

  always_comb begin
    err_ext = EXT_W'(err_sample);
    ki_term = err_ext <<< KI_SHIFT;
    kp_term = err_ext <<< KP_SHIFT;
    vel_sum = EXT_W'(vel_q) + ki_term;
    vel_nxt = clip(vel_sum);
    cmd_sum = EXT_W'(vel_nxt) + kp_term;
    cmd_o   = clip(cmd_sum);
  end

  always_ff @(posedge clk) begin
    if (rst)            vel_q <= '0;
    else if (err_valid) vel_q <= vel_nxt;
  end

  // R2
  vel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> vel_q == $past(vel_q));

  // R3
  vel_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_sample[ERR_W-1]) |=> vel_q >= $past(vel_q));

  // R3
  vel_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_sample[ERR_W-1]) |=> vel_q <= $past(vel_q));

endmodule

// File: rtl/atl_lag_filter.sv
// One-pole lag on the rate command, updated once per error strobe.
module atl_lag_filter #(
  parameter int VEL_W     = 20,
  parameter int LAG_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic signed [VEL_W-1:0] cmd_i,
  output logic signed [VEL_W-1:0] rate_q
);

  generate
    if (LAG_SHIFT == 0) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst)      rate_q <= '0;
        else if (upd) rate_q <= cmd_i;
      end
    end else begin : g_lag
      logic signed [VEL_W:0] diff;
      logic signed [VEL_W:0] step;
      logic signed [VEL_W:0] rate_sum;

      always_comb begin
        diff     = (VEL_W+1)'(cmd_i) - (VEL_W+1)'(rate_q);
        step     = diff >>> LAG_SHIFT;
        rate_sum = (VEL_W+1)'(rate_q) + step;
      end

      always_ff @(posedge clk) begin
        if (rst)      rate_q <= '0;
        else if (upd) rate_q <= rate_sum[VEL_W-1:0];
      end

      // R7
      lag_fits_chk: assert property (@(posedge clk) disable iff (rst)
        upd |-> rate_sum[VEL_W] == rate_sum[VEL_W-1]);
    end
  endgenerate

  // R7
  lag_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && cmd_i >= rate_q) |=> (rate_q >= $past(rate_q) && rate_q <= $past(cmd_i)));

endmodule

// File: rtl/atl_phase_stepper.sv
// Phase accumulator driven by the rate; carries/borrows move the angle.
module atl_phase_stepper
  import atl_pkg::*;
#(
  parameter int ANGLE_W = 16,
  parameter int ACC_W   = 19
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [ACC_W:0] rate_i,
  output logic [ANGLE_W-1:0]    ang_q
);

  localparam int SUM_W = ACC_W + 2;

  logic [ACC_W-1:0]        acc_q;
  logic signed [SUM_W-1:0] acc_sum;
  step_e                   dir;

  always_comb begin
    acc_sum = $signed({2'b00, acc_q}) + SUM_W'(rate_i);
    case ({acc_sum[SUM_W-1], acc_sum[ACC_W]})
      2'b01:   dir = STEP_UP;
      2'b10,
      2'b11:   dir = STEP_DOWN;
      default: dir = STEP_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ang_q <= '0;
    end else begin
      acc_q <= acc_sum[ACC_W-1:0];
      case (dir)
        STEP_UP:   ang_q <= ang_q + 1'b1;
        STEP_DOWN: ang_q <= ang_q - 1'b1;
        default:   ang_q <= ang_q;
      endcase
    end
  end

  // R1
  clear_chk: assert property (@(posedge clk)
    rst |=> (ang_q == '0 && acc_q == '0));

  // R4
  one_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ANGLE_W'(ang_q - $past(ang_q)) == '0 ||
              ANGLE_W'(ang_q - $past(ang_q)) == ANGLE_W'(1) ||
              ANGLE_W'(ang_q - $past(ang_q)) == '1));

  // R4
  up_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_i > 0) |=> ANGLE_W'(ang_q - $past(ang_q)) != '1);

  // R4
  down_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_i < 0) |=> ANGLE_W'(ang_q - $past(ang_q)) != ANGLE_W'(1));

endmodule

// File: rtl/angle_track_loop.sv
// Type II angle tracking loop: error -> velocity -> lead -> lag -> angle.
module angle_track_loop #(
  parameter int ANGLE_W   = 16,
  parameter int ERR_W     = 12,
  parameter int VEL_W     = 20,
  parameter int KI_SHIFT  = 0,
  parameter int KP_SHIFT  = 4,
  parameter int LAG_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err_sample,
  output logic [ANGLE_W-1:0]      angle_o,
  output logic signed [VEL_W-1:0] vel_o
);

  localparam int ACC_W = VEL_W - 1;

  logic signed [VEL_W-1:0] cmd_w;
  logic signed [VEL_W-1:0] rate_w;

  atl_vel_integrator #(
    .ERR_W    (ERR_W),
    .VEL_W    (VEL_W),
    .KI_SHIFT (KI_SHIFT),
    .KP_SHIFT (KP_SHIFT)
  ) u_vel (
    .clk        (clk),
    .rst        (rst),
    .err_valid  (err_valid),
    .err_sample (err_sample),
    .vel_q      (vel_o),
    .cmd_o      (cmd_w)
  );

  atl_lag_filter #(
    .VEL_W     (VEL_W),
    .LAG_SHIFT (LAG_SHIFT)
  ) u_lag (
    .clk    (clk),
    .rst    (rst),
    .upd    (err_valid),
    .cmd_i  (cmd_w),
    .rate_q (rate_w)
  );

  atl_phase_stepper #(
    .ANGLE_W (ANGLE_W),
    .ACC_W   (ACC_W)
  ) u_step (
    .clk    (clk),
    .rst    (rst),
    .rate_i (rate_w),
    .ang_q  (angle_o)
  );

endmodule

// File: tb/test_angle_track_loop.sv
`timescale 1ns/1ps
module test_angle_track_loop;

  localparam int AW   = 8;
  localparam int EW   = 8;
  localparam int VW   = 16;
  localparam int KI   = 0;
  localparam int KP   = 8;
  localparam int LAG  = 1;
  localparam int ACCW = VW - 1;
  localparam int VMX  = (1 << (VW-1)) - 1;
  localparam int VMN  = -(1 << (VW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic err_valid = 1'b0;
  logic signed [EW-1:0] err_sample = '0;
  logic [AW-1:0] angle_o;
  logic signed [VW-1:0] vel_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit cmp_en  = 1'b0;
  string cur_req = "R1";

  // reference state, computed from the requirements
  int m_vel = 0, m_rate = 0, m_acc = 0, m_ang = 0;

  always #2 clk = ~clk;

  angle_track_loop #(
    .ANGLE_W(AW), .ERR_W(EW), .VEL_W(VW),
    .KI_SHIFT(KI), .KP_SHIFT(KP), .LAG_SHIFT(LAG)
  ) i_angle_track_loop (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_sample(err_sample),
    .angle_o(angle_o), .vel_o(vel_o)
  );

  function automatic int clamp(input int x);
    if (x > VMX) return VMX;
    if (x < VMN) return VMN;
    return x;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_vel = 0; m_rate = 0; m_acc = 0; m_ang = 0;
    end else begin
      int s;
      int e;
      int c;
      s = m_acc + m_rate;
      if (s >= (1 << ACCW)) begin
        s = s - (1 << ACCW); m_ang = (m_ang + 1) % (1 << AW);
      end else if (s < 0) begin
        s = s + (1 << ACCW); m_ang = (m_ang + (1 << AW) - 1) % (1 << AW);
      end
      m_acc = s;
      if (err_valid) begin
        e = int'(err_sample);
        m_vel = clamp(m_vel + e * (1 << KI));
        c = clamp(m_vel + e * (1 << KP));
        m_rate = m_rate + ((c - m_rate) >>> LAG);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // continuous comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check(int'(angle_o) == m_ang, {cur_req, " angle"}, int'(angle_o), m_ang);
      check(int'(vel_o) == m_vel, {cur_req, " velocity"}, int'(vel_o), m_vel);
    end
  end

  // wrap observation for R5
  logic [AW-1:0] prev_ang = '0;
  bit up_wrap = 1'b0, down_wrap = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ang == '1 && angle_o == '0) up_wrap = 1'b1;
      if (prev_ang == '0 && angle_o == '1) down_wrap = 1'b1;
    end
    prev_ang = angle_o;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; err_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic close_loop(input int target, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      logic [AW-1:0] d;
      d = AW'(target) - angle_o;
      err_sample = $signed(d);
      err_valid = 1'b1;
      @(negedge clk);
    end
    err_valid = 1'b0;
  endtask

  initial begin
    // R1: reset state, then idle
    do_reset();
    check(angle_o == '0, "R1", int'(angle_o), 0);
    check(vel_o == '0, "R1", int'(vel_o), 0);
    repeat (50) @(negedge clk);
    check(angle_o == '0, "R1 idle", int'(angle_o), 0);
    cmp_en = 1'b1;

    // R2: exhaustive single strobe, then unstrobed garbage
    cur_req = "R2";
    for (int e = -128; e < 128; e++) begin
      do_reset();
      err_sample = EW'(e); err_valid = 1'b1;
      @(negedge clk);
      err_valid = 1'b0;
      check(int'(vel_o) == e * (1 << KI), "R2 strobe", int'(vel_o), e * (1 << KI));
      err_sample = EW'(-e - 1);
      repeat (3) @(negedge clk);
      check(int'(vel_o) == e * (1 << KI), "R2 ignored", int'(vel_o), e * (1 << KI));
    end

    // R3/R5: positive rail and upward wrap
    cur_req = "R3";
    do_reset();
    err_sample = 8'sd127; err_valid = 1'b1;
    repeat (300) @(negedge clk);
    check(int'(vel_o) == VMX, "R3 upper rail", int'(vel_o), VMX);
    repeat (40) @(negedge clk);
    check(int'(vel_o) == VMX, "R3 upper hold", int'(vel_o), VMX);
    err_valid = 1'b0;
    cur_req = "R5";
    repeat (600) @(negedge clk);
    check(up_wrap, "R5 up wrap", int'(up_wrap), 1);

    // R3/R5: negative rail and downward wrap
    cur_req = "R3";
    err_sample = -8'sd128; err_valid = 1'b1;
    repeat (600) @(negedge clk);
    check(int'(vel_o) == VMN, "R3 lower rail", int'(vel_o), VMN);
    err_valid = 1'b0;
    cur_req = "R5";
    repeat (600) @(negedge clk);
    check(down_wrap, "R5 down wrap", int'(down_wrap), 1);

    // R4/R6/R7: single +1 strobe -> rate 128 -> 4 steps in 1024 clocks
    cur_req = "R6";
    do_reset();
    err_sample = 8'sd1; err_valid = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    repeat (1024) @(negedge clk);
    check(int'(angle_o) == 4, "R6 R4 lead drives steps", int'(angle_o), 4);

    // R7: single -1 strobe -> rate floor(-257/2) = -129 -> 5 borrows -> 251
    cur_req = "R7";
    do_reset();
    err_sample = -8'sd1; err_valid = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    repeat (1024) @(negedge clk);
    check(int'(angle_o) == 251, "R7 floor rounding", int'(angle_o), 251);

    // R8: closed loop up then down
    cur_req = "R8";
    do_reset();
    close_loop(100, 6000);
    begin
      int d1;
      d1 = int'(angle_o) - 100;
      check(d1 <= 3 && d1 >= -3, "R8 up target", int'(angle_o), 100);
    end
    close_loop(20, 6000);
    begin
      int d2;
      d2 = int'(angle_o) - 20;
      check(d2 <= 3 && d2 >= -3, "R8 down target", int'(angle_o), 20);
    end

    cmp_en = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule